// File: doc/BRIEF.md
# Interleaved Memory Window Router

This block sits behind one fixed window of host memory space. Each incoming read or write carries an address relative to the start of the window. The router adds the window base to form the host physical address. It then spreads consecutive granules of that address across a set of downstream host-bridge ports, passing the access to the chosen port on a shared forward bus with a one-hot port strobe. The chosen port answers in the same cycle, saying whether some device below it claims the access, and for reads returning the data. One cycle later the router presents a registered completion.

The number of ports in the interleave set need not be a power of two. Counts with a factor of three are handled by a combinational residue-of-three circuit, so port selection never takes more than one cycle. Requests that no device claims are completed locally: a read returns zero with an error flag, and a write is acknowledged without error. The static configuration inputs are checked at all times. An illegal setting raises a configuration error and stops all forwarding.

Top module: `iw_window_router`

## Requirements
- R1: `cfg_err` is 1 whenever any of bits [27:0] of `cfg_size` is non-zero, so the window size must be a whole multiple of 256 MiB.
- R2: The granularity is 256 bytes shifted left by `cfg_gran`. Encodings 0 to 6 are legal, and 0 means 256 bytes. Encoding 7 sets `cfg_err`.
- R3: `cfg_ways` must be 1, 2, 3, 4, 6, 8 or 12, and no larger than NPORT. Any other value sets `cfg_err`. While `cfg_err` is 1, no `fwd_valid` bit is ever raised.
- R4: `fwd_addr` carries the host physical address `cfg_base + req_addr`, not the relative address. `fwd_write` and `fwd_size` mirror the request.
- R5: The target port index is `((cfg_base + req_addr) >> (8 + cfg_gran)) mod cfg_ways`. `fwd_valid` is one-hot at that index in the request cycle. This happens only when the request is valid, the configuration is legal, `req_addr < cfg_size` and the size is legal.
- R6: A forwarded read whose target port raises its `fwd_claim` bit completes with error 0. Its data is that port's `fwd_rdata` lane (bits [64p+63:64p]) with the bytes at and above `req_size` cleared.
- R7: A read that is not claimed, or not forwarded (out of window, configuration error, illegal size), completes with `cpl_rdata` = 0 and `cpl_err` = 1.
- R8: Every write completes with `cpl_err` = 0, whether claimed or not. `fwd_wdata` is `req_wdata` with every byte at and above `req_size` cleared (little-endian: byte 0 is bits [7:0]).
- R9: Access sizes 1 to 8 bytes are forwarded at any byte alignment. Sizes 0 and 9 to 15 are never forwarded.
- R10: `cpl_valid` is 1 exactly in the cycle after a cycle with `req_valid` = 1, and 0 otherwise, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | AW | Window base host address |
| cfg_size | input | AW | Window size in bytes |
| cfg_ways | input | 4 | Number of interleaved target ports |
| cfg_gran | input | 3 | Interleave granularity encoding |
| cfg_err | output | 1 | Configuration is illegal |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Window-relative byte address |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data, little-endian |
| fwd_valid | output | NPORT | One-hot forward strobe per port |
| fwd_write | output | 1 | Forwarded direction |
| fwd_addr | output | AW | Forwarded host physical address |
| fwd_size | output | 4 | Forwarded access size |
| fwd_wdata | output | 64 | Forwarded, size-masked write data |
| fwd_claim | input | NPORT | Port reports a device claims the access |
| fwd_rdata | input | NPORT*64 | Read data lanes, one per port |
| cpl_valid | output | 1 | Completion present |
| cpl_rdata | output | 64 | Completion read data |
| cpl_err | output | 1 | Completion error flag |

## Verification
In every back-to-back stretch, the forward decision for a new request and the registered completion of the previous one fall in the same cycle. A fault that lets one bleed into the other shows up there. The bench issues requests on consecutive cycles with alternating direction, size and target port. In each cycle it judges the combinational forward outputs of the current request before the edge. It judges the completion of the previous request just after the edge. Both are compared against a modulo and masking model computed arithmetically in the bench. The sweep covers every legal port count at several granularities, with a non-claiming port in the set, so unclaimed reads and writes land next to claimed ones.

// File: rtl/iwr_pkg.sv
// Shared constants, types and arithmetic helpers of the interleaved window router.
// Assumes a data path of exactly 8 byte lanes and host addresses of at most 64 bits.
package iwr_pkg;

    localparam int unsigned DATA_W         = 64;
    localparam int unsigned MAX_BYTES      = DATA_W / 8;
    localparam int unsigned GRAN_BASE_SH   = 8;   // 256-byte minimum granule
    localparam int unsigned GRAN_ENC_MAX   = 6;   // 16 KiB maximum granule
    localparam int unsigned SIZE_ALIGN_SH  = 28;  // 256 MiB window size step

    // Port count split into 2^pow or 3*2^pow
    typedef struct packed {
        logic       legal;
        logic       tri_f;
        logic [1:0] pow;
        logic [3:0] count;
    } ways_dec_t;

    // Split a port count into its power-of-two and factor-of-three parts
    function automatic ways_dec_t decode_ways(input logic [3:0] w);
        ways_dec_t d;
        d.legal = 1'b1;
        d.tri_f = 1'b0;
        d.pow   = 2'd0;
        d.count = w;
        case (w)
            4'd1:    d.pow = 2'd0;
            4'd2:    d.pow = 2'd1;
            4'd4:    d.pow = 2'd2;
            4'd8:    d.pow = 2'd3;
            4'd3:    begin d.tri_f = 1'b1; d.pow = 2'd0; end
            4'd6:    begin d.tri_f = 1'b1; d.pow = 2'd1; end
            4'd12:   begin d.tri_f = 1'b1; d.pow = 2'd2; end
            default: d.legal = 1'b0;
        endcase
        return d;
    endfunction

    // Residue of v modulo 3: even bits weigh 1, odd bits weigh 2 (since 2 = -1 mod 3)
    function automatic logic [1:0] residue3(input logic [63:0] v);
        logic [2:0] r;
        r = 3'd0;
        for (int i = 0; i < 64; i++) begin
            if (v[i]) begin
                r = r + ((i % 2 == 0) ? 3'd1 : 3'd2);
                if (r >= 3'd3) r = r - 3'd3;
            end
        end
        return r[1:0];
    endfunction

    // Byte-lane mask keeping the lowest sz bytes
    function automatic logic [DATA_W-1:0] lane_mask(input logic [3:0] sz);
        logic [DATA_W-1:0] m;
        for (int b = 0; b < MAX_BYTES; b++) begin
            m[b*8 +: 8] = (4'(b) < sz) ? 8'hFF : 8'h00;
        end
        return m;
    endfunction

endpackage

// File: rtl/iwr_cfg_check.sv
// Checks the static window configuration and decodes the port count.
// Assumes the configuration is quasi-static; the check is purely combinational.
module iwr_cfg_check
    import iwr_pkg::*;
#(
    parameter int unsigned AW    = 40,
    parameter int unsigned NPORT = 12
) (
    input  logic [AW-1:0] cfg_size,
    input  logic [3:0]    cfg_ways,
    input  logic [2:0]    cfg_gran,
    output ways_dec_t     ways_dec,
    output logic          cfg_err
);

    logic size_bad;
    logic gran_bad;
    logic ways_bad;

    // Flag each illegal setting and merge them into one error
    always_comb begin
        ways_dec = decode_ways(cfg_ways);
        size_bad = |cfg_size[SIZE_ALIGN_SH-1:0];
        gran_bad = (cfg_gran > 3'(GRAN_ENC_MAX));
        ways_bad = !ways_dec.legal || (32'(cfg_ways) > NPORT);
        cfg_err  = size_bad | gran_bad | ways_bad;
    end

endmodule

// File: rtl/iwr_port_select.sv
// Computes the target port index as (hpa / granule) mod port count in one cycle.
// Assumes ways_dec is legal whenever the index is used; counts 3, 6, 12 use a residue circuit.
module iwr_port_select
    import iwr_pkg::*;
#(
    parameter int unsigned AW   = 40,
    parameter int unsigned IDXW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   hpa,
    input  logic [2:0]      cfg_gran,
    input  ways_dec_t       ways_dec,
    input  logic            cfg_err,
    output logic [IDXW-1:0] port_idx
);

    logic [AW-1:0] granule_no;
    logic [AW-1:0] upper;
    logic [AW-1:0] low_mask;
    logic [1:0]    res3;
    logic [AW-1:0] idx_wide;

    // Granule number, power-of-two part and residue of the rest
    always_comb begin
        granule_no = hpa >> (GRAN_BASE_SH + 32'(cfg_gran));
        upper      = granule_no >> ways_dec.pow;
        low_mask   = (AW'(1) << ways_dec.pow) - AW'(1);
        res3       = residue3(64'(upper));
        if (ways_dec.tri_f) begin
            idx_wide = (AW'(res3) << ways_dec.pow) | (granule_no & low_mask);
        end else begin
            idx_wide = granule_no & low_mask;
        end
        port_idx = idx_wide[IDXW-1:0];
    end

    // R5: a legal configuration never selects a port beyond the count
    a_r5_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_err |-> (32'(port_idx) < 32'(ways_dec.count)));

endmodule

// File: rtl/iwr_completion.sv
// Registers one completion per request, applying the unclaimed-access policy.
// Assumes claim and read data are valid in the request cycle.
module iwr_completion
    import iwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              claimed,
    input  logic [DATA_W-1:0] sel_rdata,
    input  logic [DATA_W-1:0] mask,
    output logic              cpl_valid,
    output logic [DATA_W-1:0] cpl_rdata,
    output logic              cpl_err
);

    // Capture the completion: claimed reads carry data, unclaimed reads error, writes never do
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_valid <= 1'b0;
            cpl_rdata <= '0;
            cpl_err   <= 1'b0;
        end else begin
            cpl_valid <= req_valid;
            cpl_rdata <= (req_valid && !req_write && claimed) ? (sel_rdata & mask) : '0;
            cpl_err   <= req_valid && !req_write && !claimed;
        end
    end

    // R7: an error completion never carries data
    a_r7_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_err) |-> (cpl_rdata == '0));

    // R8: a write request always completes without error
    a_r8_write_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (cpl_valid && !cpl_err));

    // R10: no completion follows an idle cycle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !cpl_valid);

endmodule

// File: rtl/iw_window_router.sv
// Routes window-relative memory accesses to one of NPORT interleaved host-bridge ports.
// Assumes each port answers claim and read data combinationally in the request cycle.
module iw_window_router
    import iwr_pkg::*;
#(
    parameter int unsigned AW    = 40,
    parameter int unsigned NPORT = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           cfg_base,
    input  logic [AW-1:0]           cfg_size,
    input  logic [3:0]              cfg_ways,
    input  logic [2:0]              cfg_gran,
    output logic                    cfg_err,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [AW-1:0]           req_addr,
    input  logic [3:0]              req_size,
    input  logic [63:0]             req_wdata,
    output logic [NPORT-1:0]        fwd_valid,
    output logic                    fwd_write,
    output logic [AW-1:0]           fwd_addr,
    output logic [3:0]              fwd_size,
    output logic [63:0]             fwd_wdata,
    input  logic [NPORT-1:0]        fwd_claim,
    input  logic [NPORT*64-1:0]     fwd_rdata,
    output logic                    cpl_valid,
    output logic [63:0]             cpl_rdata,
    output logic                    cpl_err
);

    localparam int unsigned IDXW = (NPORT > 1) ? $clog2(NPORT) : 1;

    ways_dec_t         ways_dec;
    logic [AW-1:0]     hpa;
    logic [IDXW-1:0]   port_idx;
    logic              size_ok;
    logic              in_window;
    logic              route_ok;
    logic              claimed;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] sel_rdata;
    logic [DATA_W-1:0] port_rd [NPORT];

    iwr_cfg_check #(.AW(AW), .NPORT(NPORT)) u_cfg (
        .cfg_size (cfg_size),
        .cfg_ways (cfg_ways),
        .cfg_gran (cfg_gran),
        .ways_dec (ways_dec),
        .cfg_err  (cfg_err)
    );

    // Translate to host physical address and qualify the request
    always_comb begin
        hpa       = cfg_base + req_addr;
        size_ok   = (req_size != 4'd0) && (req_size <= 4'(MAX_BYTES));
        in_window = (req_addr < cfg_size);
        route_ok  = req_valid && !cfg_err && size_ok && in_window;
        mask      = lane_mask(req_size);
    end

    iwr_port_select #(.AW(AW), .IDXW(IDXW)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .hpa      (hpa),
        .cfg_gran (cfg_gran),
        .ways_dec (ways_dec),
        .cfg_err  (cfg_err),
        .port_idx (port_idx)
    );

    // One strobe and one read lane per port
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign fwd_valid[p] = route_ok && (port_idx == IDXW'(p));
        assign port_rd[p]   = fwd_rdata[p*DATA_W +: DATA_W];
    end

    // Shared forward bus and claim lookup at the selected port
    always_comb begin
        fwd_write = req_write;
        fwd_addr  = hpa;
        fwd_size  = req_size;
        fwd_wdata = req_wdata & mask;
        if (32'(port_idx) < NPORT) begin
            claimed   = route_ok && fwd_claim[port_idx];
            sel_rdata = port_rd[port_idx];
        end else begin
            claimed   = 1'b0;
            sel_rdata = '0;
        end
    end

    iwr_completion u_cpl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .claimed   (claimed),
        .sel_rdata (sel_rdata),
        .mask      (mask),
        .cpl_valid (cpl_valid),
        .cpl_rdata (cpl_rdata),
        .cpl_err   (cpl_err)
    );

    // R3: an illegal configuration blocks every forward strobe
    a_r3_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (fwd_valid == '0));

    // R5: at most one port is strobed per cycle
    a_r5_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fwd_valid));

    // R9: an illegal size is never forwarded
    a_r9_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_size == 4'd0) || (req_size > 4'd8)) |-> (fwd_valid == '0));

endmodule

// File: tb/iw_window_router_test.sv
module iw_window_router_test;

    localparam int AW    = 40;
    localparam int NPORT = 12;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [AW-1:0]       cfg_base;
    logic [AW-1:0]       cfg_size;
    logic [3:0]          cfg_ways;
    logic [2:0]          cfg_gran;
    logic                cfg_err;
    logic                req_valid = 1'b0;
    logic                req_write = 1'b0;
    logic [AW-1:0]       req_addr = '0;
    logic [3:0]          req_size = 4'd1;
    logic [63:0]         req_wdata = '0;
    logic [NPORT-1:0]    fwd_valid;
    logic                fwd_write;
    logic [AW-1:0]       fwd_addr;
    logic [3:0]          fwd_size;
    logic [63:0]         fwd_wdata;
    logic [NPORT-1:0]    fwd_claim;
    logic [NPORT*64-1:0] fwd_rdata;
    logic                cpl_valid;
    logic [63:0]         cpl_rdata;
    logic                cpl_err;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    iw_window_router #(.AW(AW), .NPORT(NPORT)) uut (.*);

    always #10 clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    function automatic logic [63:0] lane_data(int p);
        return 64'h0102_0304_0506_0708 * 64'(p + 3) ^ 64'hA5A5_0000_5A5A_FFFF;
    endfunction

    function automatic logic [63:0] keep_bytes(int sz);
        logic [63:0] m = '0;
        for (int b = 0; b < 8; b++) if (b < sz) m[b*8 +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic bit ways_ok(int w);
        return (w == 1 || w == 2 || w == 3 || w == 4 || w == 6 || w == 8 || w == 12);
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One request: check forward before the edge, completion after it
    task automatic access(bit wr, longint rel, int sz, logic [63:0] wd);
        bit cfg_good, fwd_exp, claim_exp;
        longint hpa;
        int idx;
        logic [NPORT-1:0] fv_exp;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(rel);
        req_size = 4'(sz); req_wdata = wd;
        #2;
        cfg_good = (cfg_size[27:0] == 0) && (cfg_gran <= 6) && ways_ok(int'(cfg_ways));
        hpa = longint'(cfg_base) + rel;
        idx = cfg_good ? int'((hpa >> (8 + cfg_gran)) % longint'(cfg_ways)) : 0;
        fwd_exp = cfg_good && (rel < longint'(cfg_size)) && sz >= 1 && sz <= 8;
        fv_exp = fwd_exp ? (NPORT'(1) << idx) : '0;
        claim_exp = fwd_exp && fwd_claim[idx];
        check(fwd_valid == fv_exp, "R5 R9 port strobe", 64'(fwd_valid), 64'(fv_exp));
        if (fwd_exp) begin
            check(fwd_addr == AW'(hpa), "R4 host address", 64'(fwd_addr), 64'(hpa));
            check(fwd_write == wr && fwd_size == 4'(sz), "R4 direction and size",
                  {fwd_write, fwd_size}, {wr, 4'(sz)});
        end
        if (wr) check(fwd_wdata == (wd & keep_bytes(sz)), "R8 write lanes",
                      fwd_wdata, wd & keep_bytes(sz));
        @(posedge clk); #2;
        check(cpl_valid == 1'b1, "R10 completion present", 64'(cpl_valid), 64'd1);
        if (wr) begin
            check(cpl_err == 1'b0, "R8 write no error", 64'(cpl_err), 64'd0);
        end else if (claim_exp) begin
            check(cpl_rdata == (lane_data(idx) & keep_bytes(sz)) && !cpl_err,
                  "R6 claimed read", cpl_rdata, lane_data(idx) & keep_bytes(sz));
        end else begin
            check(cpl_rdata == 64'd0 && cpl_err, "R7 unclaimed read",
                  {cpl_rdata[62:0], cpl_err}, 64'd1);
        end
        req_valid = 1'b0;
    endtask

    initial begin
        int wl[7] = '{1, 2, 3, 4, 6, 8, 12};
        cfg_base = 40'h3_7000_0000;
        cfg_size = 40'h2000_0000;
        cfg_ways = 4'd3;
        cfg_gran = 3'd0;
        fwd_claim = 12'b1011_1101_1110;  // ports 0, 5, 10 have no device
        for (int p = 0; p < NPORT; p++) fwd_rdata[p*64 +: 64] = lane_data(p);

        repeat (3) @(posedge clk);
        #2;
        // R10: quiet completion state in reset
        check(!cpl_valid && !cpl_err && cpl_rdata == 0, "R10 reset state",
              {cpl_rdata[61:0], cpl_valid, cpl_err}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2;
        check(!cpl_valid, "R10 idle after reset", 64'(cpl_valid), 64'd0);

        // R5 R6 R7 R8: sweep port counts and granularities, back to back
        for (int w = 0; w < 7; w++) begin
            for (int g = 0; g < 3; g++) begin
                cfg_ways = 4'(wl[w]); cfg_gran = 3'(g);
                for (int j = 0; j < 30; j++) begin
                    longint rel = longint'(j) * (96 << g) + (j % 5);
                    access(1'b0, rel, 1 + (j % 8), 64'hFEDC_BA98_7654_3210 + 64'(j));
                    access(1'b1, rel + 7, 8 - (j % 8), 64'h1122_3344_5566_7788 ^ 64'(j));
                end
            end
        end

        // R2: largest legal granule
        cfg_ways = 4'd12; cfg_gran = 3'd6;
        for (int j = 0; j < 24; j++) access(1'b0, longint'(j) * 16384 + 3, 4, 64'd0);
        check(cfg_err == 1'b0, "R2 encoding 6 legal", 64'(cfg_err), 64'd0);

        // R9: sizes 0..9, unaligned
        cfg_ways = 4'd6; cfg_gran = 3'd1;
        for (int s = 0; s < 10; s++) begin
            access(1'b0, 40'h1235 + longint'(s), s, 64'd0);
            access(1'b1, 40'h7773 + longint'(s), s, 64'hFFFF_FFFF_FFFF_FFFF);
        end

        // R5 R7: window edge
        access(1'b0, longint'(cfg_size) - 1, 1, 64'd0);
        access(1'b0, longint'(cfg_size), 1, 64'd0);
        access(1'b1, longint'(cfg_size) + 64, 2, 64'hABCD);

        // R10: idle cycle after a request
        @(posedge clk); #2;
        check(!cpl_valid, "R10 no completion when idle", 64'(cpl_valid), 64'd0);

        // R1: size alignment
        cfg_size = 40'h2000_1000; #1;
        check(cfg_err == 1'b1, "R1 misaligned size", 64'(cfg_err), 64'd1);
        access(1'b0, 40'h100, 8, 64'd0);
        access(1'b1, 40'h100, 8, 64'd5);
        cfg_size = 40'h1_0000_0000; #1;
        check(cfg_err == 1'b0, "R1 aligned size", 64'(cfg_err), 64'd0);

        // R2: encoding 7 illegal
        cfg_gran = 3'd7; #1;
        check(cfg_err == 1'b1, "R2 encoding 7", 64'(cfg_err), 64'd1);
        access(1'b0, 40'h400, 4, 64'd0);
        cfg_gran = 3'd0;

        // R3: every port count 0..15
        for (int w = 0; w < 16; w++) begin
            cfg_ways = 4'(w); #1;
            check(cfg_err == !ways_ok(w), "R3 port count legality",
                  64'(cfg_err), 64'(!ways_ok(w)));
            access(1'b0, 40'h900 + longint'(w) * 256, 2, 64'd0);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule